// File: doc/BRIEF.md
# External Interrupt Pending and Cascade

This block gathers 24 external interrupt request lines into a sticky pending register, applies a software mask, and folds the result onto six first-level request lines toward a CPU interrupt controller. Any source line that is high at a rising clock edge records its event in the pending register. The bit stays recorded until software clears it by writing a 1 to it.

Software sees two word registers behind a small word-addressed port: a mask word at word 0 and a pending word at word 1. The four lowest sources are wired straight to their own outputs and cannot be masked. Sources 4 to 7 share one output, and sources 8 to 23 share the last one. The outputs are combinational functions of the registered pending and mask state. They therefore follow every capture or register write without an extra pipeline stage.

Top module: `eint_cascade`

## Requirements
- R1: After asynchronous reset the pending word reads 0x00000000, the mask word reads 0x00FFFFF0 and all six irq_o lines are low.
- R2: A source line high at a rising clock edge sets bit n of the pending word (source n maps to bit n). The bit stays 1 after the line falls, until software clears it.
- R3: A write to the pending word (addr_i = 1) clears every pending bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R4: Bits 3:0 of the mask word always read 0, whatever is written to them, so sources 0 to 3 are never blocked.
- R5: A write to the mask word (addr_i = 0) stores write-data bits 23:4. A mask bit of 1 blocks its source, and the effective vector is pending AND NOT mask.
- R6: irq_o[3:0] equal effective bits 3:0 one to one.
- R7: irq_o[4] is the OR of effective bits 7:4.
- R8: irq_o[5] is the OR of effective bits 23:8.
- R9: Read bits 31:24 are 0 for both words. Addresses 2 and 3 read 0, and writes to them change nothing.
- R10: When a source capture and a clearing write hit the same pending bit in one cycle, the bit ends up set.
- R11: irq_o changes only after the clock edge that updates pending or mask, and in the same cycle as that update. A source line has no combinational path to irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | External interrupt request lines, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 mask, 1 pending |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 6 | First-level interrupt requests |

## Verification
The bench targets the race between a capture and a clearing write on the same bit. A design that let the clear win would drop the event, and the pending readback would show the bit as 0. It writes all ones to the mask and reads back to confirm that bits 3:0 and 31:24 stay 0. A design that stored them would mask the direct sources or leak high data bits. It walks each of the 24 sources alone to catch a source folded onto the wrong output. It also checks that irq_o does not move before the capturing edge, which exposes any combinational path from src_i.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_MASK = 2'd0,
    REG_PEND = 2'd1,
    REG_RSV2 = 2'd2,
    REG_RSV3 = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/eint_mask_reg.sv
module eint_mask_reg #(
  parameter int unsigned NUM_SRC    = 24,
  parameter int unsigned NUM_DIRECT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    if (b < NUM_DIRECT) begin : g_fixed
      // direct sources can never be blocked
      assign mask_o[b] = 1'b0;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= 1'b1;
        else if (wr_i) q <= wdata_i[b];
      end
      assign mask_o[b] = q;
    end
  end
endmodule

// File: rtl/eint_pend_reg.sv
module eint_pend_reg #(
  parameter int unsigned NUM_SRC = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic q, clr_bit, nxt;
    assign clr_bit = clr_i & wdata_i[b];
    // capture beats clear so no event is lost
    assign nxt = src_i[b] | (q & ~clr_bit);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= nxt;
    end
    assign pend_o[b] = q;
  end
endmodule

// File: rtl/eint_fold.sv
module eint_fold #(
  parameter int unsigned NUM_SRC    = 24,
  parameter int unsigned NUM_DIRECT = 4,
  parameter int unsigned MID_W      = 4,
  localparam int unsigned NUM_OUT   = NUM_DIRECT + 2,
  localparam int unsigned MID_LO    = NUM_DIRECT,
  localparam int unsigned MID_HI    = NUM_DIRECT + MID_W - 1,
  localparam int unsigned TOP_LO    = MID_HI + 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_OUT-1:0] irq_o
);
  logic [NUM_SRC-1:0] eff;
  assign eff = pend_i & ~mask_i;

  for (genvar o = 0; o < NUM_DIRECT; o++) begin : g_direct
    assign irq_o[o] = eff[o];
  end

  assign irq_o[NUM_DIRECT]   = |eff[MID_HI:MID_LO];
  assign irq_o[NUM_DIRECT+1] = |eff[NUM_SRC-1:TOP_LO];
endmodule

// File: rtl/eint_cascade.sv
module eint_cascade
  import eint_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 24,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_DIRECT = 4,
  parameter int unsigned MID_W      = 4,
  localparam int unsigned NUM_OUT   = NUM_DIRECT + 2,
  localparam int unsigned PAD_W     = DATA_W - NUM_SRC
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_OUT-1:0]    irq_o
);
  reg_sel_e           sel;
  logic               wr_mask, wr_pend;
  logic [NUM_SRC-1:0] wr_bits, pend_q, mask_q;
  logic               unused_hi;

  assign sel       = reg_sel_e'(addr_i);
  assign wr_mask   = wr_en_i && (sel == REG_MASK);
  assign wr_pend   = wr_en_i && (sel == REG_PEND);
  assign wr_bits   = wdata_i[NUM_SRC-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:NUM_SRC];

  eint_mask_reg #(.NUM_SRC(NUM_SRC), .NUM_DIRECT(NUM_DIRECT)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_mask),
    .wdata_i (wr_bits),
    .mask_o  (mask_q)
  );

  eint_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .clr_i   (wr_pend),
    .wdata_i (wr_bits),
    .pend_o  (pend_q)
  );

  eint_fold #(.NUM_SRC(NUM_SRC), .NUM_DIRECT(NUM_DIRECT), .MID_W(MID_W)) u_fold (
    .pend_i (pend_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (sel)
      REG_MASK: rdata_o = {{PAD_W{1'b0}}, mask_q};
      REG_PEND: rdata_o = {{PAD_W{1'b0}}, pend_q};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/eint_cascade_chk.sv
module eint_cascade_chk
  import eint_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 24,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_DIRECT = 4,
  parameter int unsigned MID_W      = 4,
  localparam int unsigned NUM_OUT   = NUM_DIRECT + 2,
  localparam int unsigned MID_HI    = NUM_DIRECT + MID_W - 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_SRC-1:0]    src_i,
  input logic                  wr_en_i,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NUM_OUT-1:0]    irq_o,
  input logic [NUM_SRC-1:0]    pend_q,
  input logic [NUM_SRC-1:0]    mask_q
);
  logic pend_wr;
  assign pend_wr = wr_en_i && (addr_i == REG_PEND);

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_wr && src_i == '0) |=> (pend_q == ($past(pend_q) & ~$past(wdata_i[NUM_SRC-1:0]))));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_wr |=> ((pend_q & $past(src_i)) == $past(src_i)));

  assert_mask_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_MASK) |-> (rdata_o[NUM_DIRECT-1:0] == '0));

  assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_SRC] == '0);

  assert_rsv_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1]) |-> (rdata_o == '0));

  assert_direct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[NUM_DIRECT-1:0] == pend_q[NUM_DIRECT-1:0]);

  assert_mid_group_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[NUM_DIRECT] == |(pend_q[MID_HI:NUM_DIRECT] & ~mask_q[MID_HI:NUM_DIRECT]));

  assert_top_group_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[NUM_DIRECT+1] == |(pend_q[NUM_SRC-1:MID_HI+1] & ~mask_q[NUM_SRC-1:MID_HI+1]));
endmodule

bind eint_cascade eint_cascade_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .NUM_DIRECT(NUM_DIRECT), .MID_W(MID_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_q  (pend_q),
  .mask_q  (mask_q)
);

// File: tb/eint_cascade_test.sv
module eint_cascade_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {wr, addr, wdata, src, chk_addr, exp_rd, exp_irq}
  localparam int VW = 1 + 2 + 32 + 24 + 2 + 32 + 6;

  function automatic logic [VW-1:0] mk(logic wr, logic [1:0] a, logic [31:0] wd,
                                       logic [23:0] s, logic [1:0] ca,
                                       logic [31:0] rd, logic [5:0] irq);
    return {wr, a, wd, s, ca, rd, irq};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0, 2'd0, 32'h0,        24'h000001, 2'd1, 32'h00000001, 6'b000001), // R2 capture direct
    mk(0, 2'd0, 32'h0,        24'h000020, 2'd1, 32'h00000021, 6'b000001), // R5 masked bit 5
    mk(1, 2'd0, 32'hFFFFFFFF, 24'h0,      2'd0, 32'h00FFFFF0, 6'b000001), // R4 R9 mask all ones
    mk(1, 2'd0, 32'h00000000, 24'h0,      2'd0, 32'h00000000, 6'b010001), // R5 R7 unmask
    mk(0, 2'd0, 32'h0,        24'h800000, 2'd1, 32'h00800021, 6'b110001), // R8 bit 23
    mk(1, 2'd1, 32'h00000001, 24'h0,      2'd1, 32'h00800020, 6'b110000), // R3 clear bit 0
    mk(1, 2'd1, 32'h00000000, 24'h0,      2'd1, 32'h00800020, 6'b110000), // R3 zero write
    mk(1, 2'd0, 32'h00800000, 24'h0,      2'd0, 32'h00800000, 6'b010000), // R5 mask bit 23
    mk(1, 2'd1, 32'h00000004, 24'h000004, 2'd1, 32'h00800024, 6'b010100), // R10 set wins
    mk(1, 2'd0, 32'h0000000F, 24'h0,      2'd0, 32'h00000000, 6'b110100), // R4 low mask ignored
    mk(1, 2'd1, 32'hFFFFFFFF, 24'h0,      2'd1, 32'h00000000, 6'b000000), // R3 clear all
    mk(0, 2'd0, 32'h0,        24'h00000E, 2'd1, 32'h0000000E, 6'b001110), // R6 direct 1..3
    mk(1, 2'd2, 32'hFFFFFFFF, 24'h0,      2'd2, 32'h00000000, 6'b001110), // R9 rsv addr 2
    mk(1, 2'd3, 32'hFFFFFFFF, 24'h0,      2'd1, 32'h0000000E, 6'b001110), // R9 rsv addr 3 no effect
    mk(1, 2'd1, 32'h0000000E, 24'h000100, 2'd1, 32'h00000100, 6'b100000)  // R8 bit 8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  eint_cascade uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] fold(logic [23:0] e);
    return {|e[23:8], |e[7:4], e[3:0]};
  endfunction

  task automatic idle_read(logic [1:0] a);
    wr_en_i = 1'b0; src_i = '0; addr_i = a; #1;
  endtask

  // one write or capture cycle, inputs applied at the falling edge
  task automatic step(logic wr, logic [1:0] a, logic [31:0] wd, logic [23:0] s);
    @(negedge clk_i);
    wr_en_i = wr; addr_i = a; wdata_i = wd; src_i = s;
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    repeat (3) @(negedge clk_i);
    // R1 reset values, sampled while reset is still held
    idle_read(2'd0); check("R1 mask", rdata_o, 32'h00FFFFF0);
    idle_read(2'd1); check("R1 pend", rdata_o, 32'h0);
    check("R1 irq", {26'h0, irq_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      step(v[VW-1], v[VW-2 -: 2], v[VW-4 -: 32], v[VW-36 -: 24]);
      idle_read(v[VW-60 -: 2]);
      check($sformatf("vec %0d rdata", i), rdata_o, v[37:6]);
      check($sformatf("vec %0d irq", i), {26'h0, irq_o}, {26'h0, v[5:0]});
    end

    // R11: no combinational path from src_i; irq follows the capturing edge
    step(1, 2'd1, 32'hFFFFFFFF, 24'h0);
    @(negedge clk_i); src_i = 24'h000010; #1;
    check("R11 before edge", {26'h0, irq_o}, 32'h0);
    @(posedge clk_i); #1; src_i = '0; #1;
    check("R11 after edge", {26'h0, irq_o}, 32'h10);

    // R2 R6 R7 R8: walk each source alone, mask cleared
    step(1, 2'd0, 32'h0, 24'h0);
    for (int s = 0; s < 24; s++) begin
      step(1, 2'd1, 32'hFFFFFFFF, 24'h0);
      step(0, 2'd0, 32'h0, 24'h1 << s);
      idle_read(2'd1);
      check($sformatf("R2 walk %0d pend", s), rdata_o, 32'h1 << s);
      check($sformatf("R6 R7 R8 walk %0d irq", s), {26'h0, irq_o},
            {26'h0, fold(24'h1 << s)});
    end

    // R1 asynchronous reset mid-operation
    step(1, 2'd0, 32'h00FF0000, 24'hFFFFFF);
    @(negedge clk_i); rst_ni = 1'b0; #1;
    idle_read(2'd0); check("R1 async mask", rdata_o, 32'h00FFFFF0);
    idle_read(2'd1); check("R1 async pend", rdata_o, 32'h0);
    check("R1 async irq", {26'h0, irq_o}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule